// File: doc/BRIEF.md
# USB Queue Head Transaction Sequencer

This block runs the execute-transaction phase of a USB host controller for one queue head. When `start` is pulsed it captures the queue head fields, the low bits of the microframe index, and whatever time the caller says is left in the microframe. It then decides whether the queue head may run in this microframe. A queue head with a nonzero S-mask belongs to the periodic (interrupt) schedule. A queue head with an all-zero S-mask belongs to the asynchronous schedule and is gated by its NAK counter.

If the queue head is eligible, the block loads a per-queue-head transaction budget from the Mult field and sets the reclamation status flag. It then issues transaction requests one at a time to an external transaction engine. Each result carries a handshake, an error flag and a byte count. The block consumes that result, reduces the remaining-bytes count in its overlay copy and decrements the budget.

The sequence stops on the first of these: the budget is used up, a non-ACK handshake arrives, an error is reported, the queue head becomes inactive, or the microframe runs out of time. On stopping, the block pulses `done` with a code that names the cause. The caller reads back the updated byte count, the NAK count and the reclamation flag.

Top module: `qh_txn_sequencer`

## Requirements
- R1: A queue head with a nonzero S-mask is periodic and is eligible only when S-mask bit number `uframe_idx` is 1. For example, mask 0x20 matches only index 5. An ineligible queue head ends with exit code 6 and issues no request.
- R2: For an all-zero S-mask, when `nak_reload_pending` is 1 at start, the NAK count is replaced by `nak_reload` before the eligibility test. The replaced value is visible on `nak_cnt`. Otherwise `nak_cnt` takes `nak_cnt_in`.
- R3: An asynchronous queue head is eligible when its NAK count is nonzero or `nak_reload` is zero. Otherwise it ends with code 6, issues no request and leaves `reclaim` at 0.
- R4: The budget is loaded from `mult`. A periodic queue head with `mult` = 0 ends with code 1, issues no request and leaves `reclaim` at 0. An asynchronous queue head with `mult` = 0 is given a budget of one transaction.
- R5: `reclaim` is cleared on start and set to 1 once an eligible queue head with a nonzero budget enters execution. It holds until the next start.
- R6: Before each request the block requires `time_left >= txn_time`. Equality is enough. When the condition fails it ends with code 5.
- R7: Each consumed result decrements the budget by one. When the budget reaches zero after an ACK, the block ends with code 1.
- R8: Handshake encoding is ACK=0, NAK=1, NYET=2, STALL=3. Any handshake other than ACK ends the sequence with code 2 and leaves the byte count unchanged.
- R9: A result with `txn_err` = 1 ends the sequence with code 3 and leaves the byte count unchanged.
- R10: If `active` is 0 when a request would be issued, the block ends with code 4 without issuing it.
- R11: An ACK result with no error reduces `total_bytes` by `txn_bytes`.
- R12: An ACK whose `txn_bytes` exceeds the remaining count sets `total_bytes` to 0 rather than wrapping, and ends with code 3.
- R13: After reset `done`, `txn_req` and `reclaim` are 0 and `exit_code` is 0. `done` and `txn_req` are single-cycle pulses. `exit_code` holds until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a sequence (accepted only while idle) |
| smask | input | 8 | Queue head S-mask; zero means asynchronous |
| mult | input | 2 | Transactions allowed per microframe |
| nak_cnt_in | input | 4 | Current NAK count of the queue head |
| nak_reload | input | 4 | NAK count reload value |
| nak_reload_pending | input | 1 | A reload of the NAK count is due |
| active | input | 1 | Queue head Active bit, sampled before each request |
| total_bytes_in | input | 15 | Remaining bytes to transfer at start |
| uframe_idx | input | 3 | Microframe index bits [2:0] |
| time_left | input | 16 | Time remaining in the microframe |
| txn_time | input | 16 | Time one transaction needs |
| txn_req | output | 1 | One-cycle request to the transaction engine |
| txn_resp_valid | input | 1 | Result of the outstanding request is present |
| txn_hs | input | 2 | Result handshake (ACK=0, NAK=1, NYET=2, STALL=3) |
| txn_err | input | 1 | Result reports a transaction error |
| txn_bytes | input | 11 | Bytes moved by the transaction |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| exit_code | output | 3 | 1 budget, 2 handshake, 3 error, 4 inactive, 5 no time, 6 not eligible |
| reclaim | output | 1 | Reclamation status flag |
| total_bytes | output | 15 | Overlay remaining-bytes count |
| nak_cnt | output | 4 | NAK count after any reload |

## Verification
Some properties are checked on every cycle:
- requests and `done` are single pulses;
- a request is raised only after a cycle in which the queue head was active and had enough time;
- `reclaim` is high whenever a request is outstanding;
- the budget never decrements below zero;
- the overlay byte count never rises during a sequence;
- a not-eligible exit never leaves `reclaim` set.

Other behaviour only shows in the bench's scripted scenarios:
- which exit code each cause produces and how the causes are prioritised;
- the exact number of requests issued;
- the S-mask index match;
- the NAK reload;
- the special cases for a zero Mult value;
- clamping of the byte count when too many bytes are reported;
- the equal-time boundary.

// File: rtl/usbq_pkg.sv
package usbq_pkg;

    localparam int SMASK_W = 8;
    localparam int MULT_W  = 2;
    localparam int NAK_W   = 4;
    localparam int TOT_W   = 15;
    localparam int BYTES_W = 11;
    localparam int TIME_W  = 16;

    typedef enum logic [2:0] {
        EXIT_NONE      = 3'd0,
        EXIT_BUDGET    = 3'd1,
        EXIT_HANDSHAKE = 3'd2,
        EXIT_XACT_ERR  = 3'd3,
        EXIT_INACTIVE  = 3'd4,
        EXIT_NO_TIME   = 3'd5,
        EXIT_NOT_ELIG  = 3'd6
    } exit_e;

    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_NYET  = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT
    } seq_state_e;

    // Outcome of the pre-operation stage, captured at start.
    typedef struct packed {
        logic              periodic;
        logic              eligible;
        logic [NAK_W-1:0]  nak;
    } qh_pre_t;

    // One result handed back by the transaction engine.
    typedef struct packed {
        hs_e                 hs;
        logic                err;
        logic [BYTES_W-1:0]  bytes;
    } txn_result_t;

    function automatic logic uframe_hit(input logic [SMASK_W-1:0] m,
                                        input logic [$clog2(SMASK_W)-1:0] idx);
        return m[idx];
    endfunction

endpackage

// File: rtl/qh_select.sv
module qh_select
    import usbq_pkg::*;
#(
    parameter int SM_W  = SMASK_W,
    parameter int N_W   = NAK_W,
    parameter int M_W   = MULT_W,
    localparam int IDX_W = $clog2(SM_W)
) (
    input  logic [SM_W-1:0]  smask,
    input  logic [IDX_W-1:0] uframe_idx,
    input  logic [N_W-1:0]   nak_cnt_in,
    input  logic [N_W-1:0]   nak_reload,
    input  logic             nak_reload_pending,
    input  logic [M_W-1:0]   mult,
    output qh_pre_t          pre,
    output logic [M_W-1:0]   budget_init
);
    logic            is_periodic;
    logic [N_W-1:0]  nak_eff;

    always_comb begin
        is_periodic = |smask;
        // R2: reload happens before the asynchronous eligibility test
        nak_eff = (!is_periodic && nak_reload_pending) ? nak_reload : nak_cnt_in;
        pre.periodic = is_periodic;
        pre.nak      = nak_eff;
        if (is_periodic)
            pre.eligible = uframe_hit(smask, uframe_idx);           // R1
        else
            pre.eligible = (nak_eff != '0) || (nak_reload == '0);   // R3
        // R4: asynchronous heads may ignore a zero Mult and run once
        if (!is_periodic && mult == '0)
            budget_init = M_W'(1);
        else
            budget_init = mult;
    end
endmodule

// File: rtl/qh_budget.sv
module qh_budget #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q == W'(1));

    // R7: a result is never consumed against an empty budget
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> !is_zero);
endmodule

// File: rtl/qh_overlay.sv
module qh_overlay #(
    parameter int T_W = 15,
    parameter int B_W = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [T_W-1:0] load_val,
    input  logic           apply,
    input  logic [B_W-1:0] bytes,
    output logic           overrun,
    output logic [T_W-1:0] remain
);
    localparam int CMP_W = (T_W > B_W) ? T_W : B_W;

    logic [T_W-1:0]   rem_q;
    logic [CMP_W-1:0] rem_x, bytes_x;

    assign rem_x   = CMP_W'(rem_q);
    assign bytes_x = CMP_W'(bytes);
    assign overrun = bytes_x > rem_x;

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (load)
            rem_q <= load_val;
        else if (apply)
            rem_q <= overrun ? '0 : T_W'(rem_x - bytes_x);   // R11, R12
    end

    assign remain = rem_q;

    // R11/R12: outside a load the count can only fall
    a_r11_no_increase: assert property (@(posedge clk) disable iff (rst)
        !load |=> remain <= $past(remain));
endmodule

// File: rtl/qh_txn_sequencer.sv
module qh_txn_sequencer
    import usbq_pkg::*;
#(
    parameter int SM_W = SMASK_W,
    parameter int M_W  = MULT_W,
    parameter int N_W  = NAK_W,
    parameter int T_W  = TOT_W,
    parameter int B_W  = BYTES_W,
    parameter int TM_W = TIME_W,
    localparam int IDX_W = $clog2(SM_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SM_W-1:0]  smask,
    input  logic [M_W-1:0]   mult,
    input  logic [N_W-1:0]   nak_cnt_in,
    input  logic [N_W-1:0]   nak_reload,
    input  logic             nak_reload_pending,
    input  logic             active,
    input  logic [T_W-1:0]   total_bytes_in,
    input  logic [IDX_W-1:0] uframe_idx,
    input  logic [TM_W-1:0]  time_left,
    input  logic [TM_W-1:0]  txn_time,
    output logic             txn_req,
    input  logic             txn_resp_valid,
    input  logic [1:0]       txn_hs,
    input  logic             txn_err,
    input  logic [B_W-1:0]   txn_bytes,
    output logic             done,
    output logic [2:0]       exit_code,
    output logic             reclaim,
    output logic [T_W-1:0]   total_bytes,
    output logic [N_W-1:0]   nak_cnt
);
    seq_state_e   state_q;
    qh_pre_t      pre_now, pre_q;
    logic [M_W-1:0] budget_init;
    logic         accept, consume, apply_bytes;
    logic         bud_zero, bud_last, overrun;
    exit_e        exit_q;
    txn_result_t  res;

    assign res.hs    = hs_e'(txn_hs);
    assign res.err   = txn_err;
    assign res.bytes = txn_bytes;

    assign accept      = (state_q == ST_IDLE) && start;
    assign consume     = (state_q == ST_WAIT) && txn_resp_valid;
    assign apply_bytes = consume && !res.err && (res.hs == HS_ACK);

    qh_select #(.SM_W(SM_W), .N_W(N_W), .M_W(M_W)) u_select (
        .smask              (smask),
        .uframe_idx         (uframe_idx),
        .nak_cnt_in         (nak_cnt_in),
        .nak_reload         (nak_reload),
        .nak_reload_pending (nak_reload_pending),
        .mult               (mult),
        .pre                (pre_now),
        .budget_init        (budget_init)
    );

    qh_budget #(.W(M_W)) u_budget (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (budget_init),
        .dec      (consume),
        .is_zero  (bud_zero),
        .is_last  (bud_last)
    );

    qh_overlay #(.T_W(T_W), .B_W(B_W)) u_overlay (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (total_bytes_in),
        .apply    (apply_bytes),
        .bytes    (res.bytes),
        .overrun  (overrun),
        .remain   (total_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pre_q   <= '0;
            exit_q  <= EXIT_NONE;
            reclaim <= 1'b0;
            txn_req <= 1'b0;
            done    <= 1'b0;
        end else begin
            txn_req <= 1'b0;
            done    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pre_q   <= pre_now;
                        exit_q  <= EXIT_NONE;
                        reclaim <= 1'b0;          // R5
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (!pre_q.eligible) begin
                        exit_q  <= EXIT_NOT_ELIG; // R1, R3
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (pre_q.periodic && bud_zero) begin
                        exit_q  <= EXIT_BUDGET;   // R4
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        reclaim <= 1'b1;          // R5
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (!active) begin
                        exit_q  <= EXIT_INACTIVE; // R10
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (time_left < txn_time) begin
                        exit_q  <= EXIT_NO_TIME;  // R6
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        txn_req <= 1'b1;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (txn_resp_valid) begin
                        if (res.err) begin
                            exit_q  <= EXIT_XACT_ERR;  // R9
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (res.hs != HS_ACK) begin
                            exit_q  <= EXIT_HANDSHAKE; // R8
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (overrun) begin
                            exit_q  <= EXIT_XACT_ERR;  // R12
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (bud_last) begin
                            exit_q  <= EXIT_BUDGET;    // R7
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign exit_code = exit_q;
    assign nak_cnt   = pre_q.nak;

    // R13: single-cycle pulses
    a_r13_req_pulse: assert property (@(posedge clk) disable iff (rst)
        txn_req |=> !txn_req);
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: a request follows a cycle with enough time
    a_r6_time_ok: assert property (@(posedge clk) disable iff (rst)
        txn_req |-> $past(time_left) >= $past(txn_time));
    // R10: a request follows a cycle in which the head was active
    a_r10_active_ok: assert property (@(posedge clk) disable iff (rst)
        txn_req |-> $past(active));
    // R5: execution has been entered whenever a request is out
    a_r5_reclaim_set: assert property (@(posedge clk) disable iff (rst)
        txn_req |-> reclaim);
    // R3: a skipped head never marks reclamation
    a_r3_skip_no_reclaim: assert property (@(posedge clk) disable iff (rst)
        (done && exit_code == 3'd6) |-> !reclaim);
endmodule

// File: tb/qh_txn_sequencer_tb.sv
module qh_txn_sequencer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  smask = '0;
    logic [1:0]  mult = '0;
    logic [3:0]  nak_cnt_in = '0, nak_reload = '0;
    logic        nak_reload_pending = 1'b0;
    logic        active = 1'b1;
    logic [14:0] total_bytes_in = '0;
    logic [2:0]  uframe_idx = '0;
    logic [15:0] time_left = '0, txn_time = '0;
    logic        txn_req;
    logic        txn_resp_valid = 1'b0;
    logic [1:0]  txn_hs = '0;
    logic        txn_err = 1'b0;
    logic [10:0] txn_bytes = '0;
    logic        done;
    logic [2:0]  exit_code;
    logic        reclaim;
    logic [14:0] total_bytes;
    logic [3:0]  nak_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    qh_txn_sequencer dut_i (
        .clk(clk), .rst(rst), .start(start), .smask(smask), .mult(mult),
        .nak_cnt_in(nak_cnt_in), .nak_reload(nak_reload),
        .nak_reload_pending(nak_reload_pending), .active(active),
        .total_bytes_in(total_bytes_in), .uframe_idx(uframe_idx),
        .time_left(time_left), .txn_time(txn_time), .txn_req(txn_req),
        .txn_resp_valid(txn_resp_valid), .txn_hs(txn_hs), .txn_err(txn_err),
        .txn_bytes(txn_bytes), .done(done), .exit_code(exit_code),
        .reclaim(reclaim), .total_bytes(total_bytes), .nak_cnt(nak_cnt)
    );

    typedef struct {
        string       tag;
        logic [2:0]  code;
        logic [14:0] total;
        logic [3:0]  nak;
        logic        rec;
        int          txns;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0, errors = 0, completed = 0, txn_seen = 0;
    bit finished = 0;

    logic [1:0]  r_hs[4];
    logic        r_err[4];
    logic [10:0] r_by[4];
    int ridx = 0, drop_act = 0, drop_time = 0;
    logic prev_done = 1'b0;

    task automatic check(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Engine model: answers each request with the next scripted result.
    always @(negedge clk) begin
        if (txn_req) begin
            txn_resp_valid = 1'b1;
            txn_hs    = r_hs[ridx];
            txn_err   = r_err[ridx];
            txn_bytes = r_by[ridx];
            ridx++;
            if (ridx == drop_act)  active = 1'b0;
            if (ridx == drop_time) time_left = '0;
        end else begin
            txn_resp_valid = 1'b0;
        end
    end

    // Monitor: pops the expected outcome whenever a sequence finishes.
    always @(negedge clk) begin
        if (!rst) begin
            if (txn_req) txn_seen++;
            if (done && prev_done) check("R13", "done_width", 2, 1);
            prev_done = done;
            if (done) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "exit_code", int'(exit_code), int'(e.code));
                check(e.tag, "total_bytes", int'(total_bytes), int'(e.total));
                check(e.tag, "nak_cnt", int'(nak_cnt), int'(e.nak));
                check(e.tag, "reclaim", int'(reclaim), int'(e.rec));
                check(e.tag, "requests", txn_seen, e.txns);
                txn_seen = 0;
                completed++;
            end
        end
    end

    task automatic set_resp(input int i, input logic [1:0] hs, input logic err, input logic [10:0] by);
        r_hs[i] = hs; r_err[i] = err; r_by[i] = by;
    endtask

    task automatic run_case(input string tag, input logic [7:0] sm, input logic [2:0] ui,
                            input logic [1:0] mu, input logic [3:0] nk, input logic [3:0] rl,
                            input logic pend, input logic act, input logic [14:0] tot,
                            input logic [15:0] tl, input logic [15:0] tt,
                            input int da, input int dt,
                            input logic [2:0] ecode, input logic [14:0] etot,
                            input logic [3:0] enak, input logic erec, input int etx);
        exp_t e;
        int target;
        e.tag = tag; e.code = ecode; e.total = etot; e.nak = enak; e.rec = erec; e.txns = etx;
        exp_q.push_back(e);
        target = completed + 1;
        @(negedge clk);
        smask = sm; uframe_idx = ui; mult = mu; nak_cnt_in = nk; nak_reload = rl;
        nak_reload_pending = pend; active = act; total_bytes_in = tot;
        time_left = tl; txn_time = tt; ridx = 0; drop_act = da; drop_time = dt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (completed == target);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        check("R13", "reset_done", int'(done), 0);
        check("R13", "reset_req", int'(txn_req), 0);
        check("R13", "reset_reclaim", int'(reclaim), 0);
        check("R13", "reset_code", int'(exit_code), 0);

        // R1 R7 R11: periodic match, three ACKs drain the budget
        set_resp(0, 2'd0, 0, 11'd10); set_resp(1, 2'd0, 0, 11'd20); set_resp(2, 2'd0, 0, 11'd30);
        run_case("R1", 8'h20, 3'd5, 2'd3, 4'd0, 4'd0, 0, 1, 15'd100, 16'd200, 16'd50, 0, 0,
                 3'd1, 15'd40, 4'd0, 1, 3);
        // R1: mask bit not selected by index
        run_case("R1", 8'h20, 3'd4, 2'd3, 4'd0, 4'd0, 0, 1, 15'd100, 16'd200, 16'd50, 0, 0,
                 3'd6, 15'd100, 4'd0, 0, 0);
        // R4: periodic with zero Mult
        run_case("R4", 8'h01, 3'd0, 2'd0, 4'd0, 4'd0, 0, 1, 15'd100, 16'd200, 16'd50, 0, 0,
                 3'd1, 15'd100, 4'd0, 0, 0);
        // R3 R8: async, both counts zero, NAK handshake
        set_resp(0, 2'd1, 0, 11'd7);
        run_case("R8", 8'h00, 3'd0, 2'd2, 4'd0, 4'd0, 0, 1, 15'd50, 16'd200, 16'd50, 0, 0,
                 3'd2, 15'd50, 4'd0, 1, 1);
        // R3: async gated off by the NAK count
        run_case("R3", 8'h00, 3'd0, 2'd2, 4'd0, 4'd5, 0, 1, 15'd50, 16'd200, 16'd50, 0, 0,
                 3'd6, 15'd50, 4'd0, 0, 0);
        // R2: reload makes the head eligible
        set_resp(0, 2'd0, 0, 11'd8);
        run_case("R2", 8'h00, 3'd0, 2'd1, 4'd0, 4'd5, 1, 1, 15'd8, 16'd200, 16'd50, 0, 0,
                 3'd1, 15'd0, 4'd5, 1, 1);
        // R4: async with zero Mult runs once
        set_resp(0, 2'd0, 0, 11'd4);
        run_case("R4", 8'h00, 3'd0, 2'd0, 4'd3, 4'd7, 0, 1, 15'd20, 16'd200, 16'd50, 0, 0,
                 3'd1, 15'd16, 4'd3, 1, 1);
        // R9: error on second transaction
        set_resp(0, 2'd0, 0, 11'd10); set_resp(1, 2'd0, 1, 11'd7);
        run_case("R9", 8'hFF, 3'd3, 2'd3, 4'd0, 4'd0, 0, 1, 15'd60, 16'd200, 16'd50, 0, 0,
                 3'd3, 15'd50, 4'd0, 1, 2);
        // R12: more bytes than remain
        set_resp(0, 2'd0, 0, 11'd9);
        run_case("R12", 8'h00, 3'd0, 2'd2, 4'd1, 4'd0, 0, 1, 15'd5, 16'd200, 16'd50, 0, 0,
                 3'd3, 15'd0, 4'd1, 1, 1);
        // R10: inactive from the start
        run_case("R10", 8'h00, 3'd0, 2'd1, 4'd1, 4'd0, 0, 0, 15'd30, 16'd200, 16'd50, 0, 0,
                 3'd4, 15'd30, 4'd1, 1, 0);
        // R10: Active drops after the first transaction
        set_resp(0, 2'd0, 0, 11'd5);
        run_case("R10", 8'h00, 3'd0, 2'd3, 4'd1, 4'd0, 0, 1, 15'd30, 16'd200, 16'd50, 1, 0,
                 3'd4, 15'd25, 4'd1, 1, 1);
        // R6: not enough time for the first transaction
        run_case("R6", 8'h00, 3'd0, 2'd3, 4'd1, 4'd0, 0, 1, 15'd30, 16'd40, 16'd50, 0, 0,
                 3'd5, 15'd30, 4'd1, 1, 0);
        // R6: equal time suffices; time runs out after two
        set_resp(0, 2'd0, 0, 11'd1); set_resp(1, 2'd0, 0, 11'd1);
        run_case("R6", 8'h00, 3'd0, 2'd3, 4'd1, 4'd0, 0, 1, 15'd30, 16'd50, 16'd50, 0, 2,
                 3'd5, 15'd28, 4'd1, 1, 2);
        // R8: STALL on a periodic head
        set_resp(0, 2'd3, 0, 11'd6);
        run_case("R8", 8'h80, 3'd7, 2'd2, 4'd0, 4'd0, 0, 1, 15'd40, 16'd200, 16'd50, 0, 0,
                 3'd2, 15'd40, 4'd0, 1, 1);
        // R7: zero-length ACKs still consume the budget
        set_resp(0, 2'd0, 0, 11'd0); set_resp(1, 2'd0, 0, 11'd0); set_resp(2, 2'd0, 0, 11'd0);
        run_case("R7", 8'h04, 3'd2, 2'd3, 4'd0, 4'd0, 0, 1, 15'd12, 16'd200, 16'd50, 0, 0,
                 3'd1, 15'd12, 4'd0, 1, 3);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule